// File: doc/BRIEF.md
# Half-Integer Clock Pre-Divider

This block divides a clock by a ratio that may be a whole number or a whole number plus one half (1, 1.5, 2, 2.5, ...). The source clock is not used directly. Instead the block is given a tick on its own system clock for every edge of the source, so each tick marks one source half-period. The divided clock is produced as a registered level together with a one-cycle pulse that flags each of its rising edges. The whole design therefore lives in one synchronous domain.

The ratio is a field `h` in the low `HID_W` bits of a configuration word. A nonzero `h` gives an output rate of `2 / (h + 1)` times the input rate, so an odd `h` gives an integer ratio and an even `h` gives a half-integer ratio. A value of zero means no division. The configuration word is captured only on a commit pulse, and the captured value is held back until the output period in progress has ended. This keeps every period whole. Software picks `h` as `ceil(2 * parent / target) - 1`, clamped to the field maximum, before it writes the word.

Top module: `halfstep_prediv`

## Requirements
- R1: While `rst` is high and after it is released, until the first tick, `div_clk` and `div_rise` are 0 and the active field is 0 (bypass).
- R2: With an active field `h` other than 0, one output period spans `h + 1` ticks, for an output rate of input rate x 2 / (h + 1).
- R3: With an active field `h` other than 0, the output is high for `floor((h + 1) / 2)` ticks at the start of each period and low for the remaining ticks.
- R4: An active field of 0 bypasses division. The output follows the input, high for one tick and low for one tick, and the first tick after reset drives it high.
- R5: The field is `cfg_word[HID_W-1:0]`. The bits above it have no effect.
- R6: A change on `cfg_word` without a `commit` pulse has no effect on the output.
- R7: A committed field takes effect at the next rising edge of the output. The period in progress completes with the old field.
- R8: If several commits arrive within one output period, the last one is applied. A commit in the same cycle as the period boundary is applied at the following boundary.
- R9: In a cycle without `tick`, `div_clk` keeps its value.
- R10: `div_rise` is 1 for exactly the cycles in which `div_clk` has just changed from 0 to 1.
- R11: The largest field value, `2^HID_W - 1`, gives a period of `2^HID_W` ticks, split evenly between high and low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One pulse per source clock edge (one source half-period) |
| commit | input | 1 | Captures `cfg_word` as the pending configuration |
| cfg_word | input | CFG_W | Configuration word. Ratio field in bits `HID_W-1:0` |
| div_clk | output | 1 | Divided clock level, registered |
| div_rise | output | 1 | One-cycle pulse on each rising edge of `div_clk` |

## Verification
The bench targets the half-integer settings, where a design that splits the high and low phases wrongly produces a period of the right length but the wrong duty cycle. It issues a commit while a period is running, which exposes a design that switches ratio mid-period and emits a truncated or stretched period. It issues back-to-back commits and a commit that lands on a boundary, which catch a design that keeps the first value or applies a commit one period early. It also uses sparse ticks, the field maximum, and upper configuration bits that must be ignored, which catch a counter that advances without a tick and field-width slips.

// File: rtl/halfstep_prediv_pkg.sv
package halfstep_prediv_pkg;

  // Ticks spent high in one output period for field value h (bypass counts as h = 1).
  function automatic int unsigned high_ticks(int unsigned h);
    return (h == 0) ? 1 : (h + 1) / 2;
  endfunction

  // Index of the final tick position in a period.
  function automatic int unsigned final_pos(int unsigned h);
    return (h == 0) ? 1 : h;
  endfunction

endpackage

// File: rtl/halfstep_stage.sv
module halfstep_stage #(
  parameter int HID_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [HID_W-1:0] field_in,
  input  logic             wrap,
  output logic [HID_W-1:0] act_h,
  output logic [HID_W-1:0] pend_h,
  output logic             pend_vld
);

  // Pending slot: the latest commit wins. The active slot changes only at a period boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_h    <= '0;
      pend_h   <= '0;
      pend_vld <= 1'b0;
    end else begin
      if (wrap && pend_vld)
        act_h <= pend_h;
      if (commit) begin
        pend_h   <= field_in;
        pend_vld <= 1'b1;
      end else if (wrap) begin
        pend_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/halfstep_phase.sv
module halfstep_phase
  import halfstep_prediv_pkg::*;
#(
  parameter int HID_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [HID_W-1:0] act_h,
  input  logic [HID_W-1:0] pend_h,
  input  logic             pend_vld,
  output logic             wrap,
  output logic             div_clk,
  output logic             div_rise
);

  logic [HID_W-1:0] pos;
  logic [HID_W-1:0] last_pos;
  logic [HID_W-1:0] pos_n;
  logic [HID_W-1:0] next_h;
  int unsigned      next_hi;
  logic             clk_n;

  assign last_pos = HID_W'(final_pos(32'(act_h)));
  assign wrap     = tick && (pos == last_pos);
  assign next_h   = (wrap && pend_vld) ? pend_h : act_h;
  assign pos_n    = wrap ? '0 : pos + 1'b1;
  assign next_hi  = high_ticks(32'(next_h));
  assign clk_n    = (32'(pos_n) < next_hi);

  // Reset parks the counter on the last low slot, so the first tick opens a period.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= HID_W'(1);
      div_clk  <= 1'b0;
      div_rise <= 1'b0;
    end else if (tick) begin
      pos      <= pos_n;
      div_clk  <= clk_n;
      div_rise <= clk_n & ~div_clk;
    end else begin
      div_rise <= 1'b0;
    end
  end

endmodule

// File: rtl/halfstep_prediv.sv
module halfstep_prediv #(
  parameter int HID_W = 5,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             commit,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             div_clk,
  output logic             div_rise
);

  localparam int FIELD_LSB = 0;

  logic [HID_W-1:0] field_in;
  logic [HID_W-1:0] act_h;
  logic [HID_W-1:0] pend_h;
  logic             pend_vld;
  logic             wrap;

  assign field_in = cfg_word[FIELD_LSB +: HID_W];

  halfstep_stage #(.HID_W(HID_W)) stage_i (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit),
    .field_in (field_in),
    .wrap     (wrap),
    .act_h    (act_h),
    .pend_h   (pend_h),
    .pend_vld (pend_vld)
  );

  halfstep_phase #(.HID_W(HID_W)) phase_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .act_h    (act_h),
    .pend_h   (pend_h),
    .pend_vld (pend_vld),
    .wrap     (wrap),
    .div_clk  (div_clk),
    .div_rise (div_rise)
  );

endmodule

// File: rtl/halfstep_prediv_chk.sv
module halfstep_prediv_chk #(
  parameter int HID_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             commit,
  input logic             div_clk,
  input logic             div_rise,
  input logic [HID_W-1:0] act_h,
  input logic             pend_vld
);

  // R10
  rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    div_rise |-> (div_clk && !$past(div_clk)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(div_clk));

  // R7
  ratio_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (act_h != $past(act_h)) |-> div_rise);

  // R6
  commit_capture_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> pend_vld);

endmodule

bind halfstep_prediv halfstep_prediv_chk #(.HID_W(HID_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .commit   (commit),
  .div_clk  (div_clk),
  .div_rise (div_rise),
  .act_h    (act_h),
  .pend_vld (pend_vld)
);

// File: tb/halfstep_prediv_tb_top.sv
`timescale 1ns/1ps
module halfstep_prediv_tb_top;
  localparam int HID_W = 5;
  localparam int CFG_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic commit = 1'b0;
  logic [CFG_W-1:0] cfg_word = '0;
  logic div_clk, div_rise;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  halfstep_prediv #(.HID_W(HID_W), .CFG_W(CFG_W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .commit(commit),
    .cfg_word(cfg_word), .div_clk(div_clk), .div_rise(div_rise)
  );

  // Behavioural reference: a phase flag plus ticks remaining in that phase.
  bit m_out, m_rise, m_pend;
  int m_rem, m_act, m_pend_h;

  function automatic int hi_of(int h);
    return (h == 0) ? 1 : (h + 1) / 2;
  endfunction
  function automatic int lo_of(int h);
    return (h == 0) ? 1 : (h + 1) - hi_of(h);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_out = 0; m_rise = 0; m_pend = 0; m_rem = 1; m_act = 0; m_pend_h = 0;
    end else begin
      m_rise = 0;
      if (tick) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          if (m_out) begin
            m_out = 0; m_rem = lo_of(m_act);
          end else begin
            if (m_pend) begin m_act = m_pend_h; m_pend = 0; end
            m_out = 1; m_rise = 1; m_rem = hi_of(m_act);
          end
        end
      end
      if (commit) begin m_pend = 1; m_pend_h = int'(cfg_word[HID_W-1:0]); end
    end
  end

  task automatic chk(bit ok, string t, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(div_clk == m_out, tag, "div_clk vs model", int'(div_clk), int'(m_out));
      chk(div_rise == m_rise, "R10", "div_rise vs model", int'(div_rise), int'(m_rise));
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL (all) watchdog actual=%0d expected<%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic apply_cfg(logic [CFG_W-1:0] w);
    @(negedge clk); commit = 1'b1; cfg_word = w;
    @(negedge clk); commit = 1'b0;
  endtask

  task automatic wait_rise();
    int n = 0;
    do begin @(negedge clk); n++; end while (!div_rise && n < 300);
  endtask

  // Starts at a negedge showing a rise; returns at the negedge of the next rise.
  task automatic count_period(output int hi, output int lo);
    hi = 0; lo = 0;
    while (div_clk && hi < 100) begin hi++; @(negedge clk); commit = 1'b0; end
    while (!div_rise && lo < 100) begin lo++; @(negedge clk); commit = 1'b0; end
  endtask

  task automatic measure(int h, string t);
    int hi, lo, dh, dl;
    wait_rise();
    count_period(dh, dl);
    count_period(hi, lo);
    chk(hi + lo == ((h == 0) ? 2 : h + 1), t, "period ticks", hi + lo, (h == 0) ? 2 : h + 1);
    chk(hi == hi_of(h), t, "high ticks", hi, hi_of(h));
    chk(lo == lo_of(h), t, "low ticks", lo, lo_of(h));
  endtask

  initial begin
    int hi, lo;
    bit [7:0] lfsr;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(div_clk == 0, "R1", "div_clk in reset", int'(div_clk), 0);
    chk(div_rise == 0, "R1", "div_rise in reset", int'(div_rise), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(div_clk == 0, "R1", "div_clk before first tick", int'(div_clk), 0);
    // R4: bypass, first tick raises the output
    tag = "R4"; tick = 1'b1;
    @(negedge clk);
    chk(div_clk == 1, "R4", "first tick raises output", int'(div_clk), 1);
    measure(0, "R4");
    // R2 / R3: several ratios including half-integer
    tag = "R2"; apply_cfg(16'd4); measure(4, "R2");
    tag = "R3"; apply_cfg(16'd2); measure(2, "R3");
    apply_cfg(16'd7); measure(7, "R3");
    apply_cfg(16'd1); measure(1, "R2");
    apply_cfg(16'd8); measure(8, "R3");
    // R11: field maximum
    tag = "R11"; apply_cfg(16'd31); measure(31, "R11");
    // R5: upper bits ignored
    tag = "R5"; apply_cfg(16'hFFE3); measure(3, "R5");
    // R6: word changes without commit
    tag = "R6"; cfg_word = 16'd9;
    repeat (20) @(negedge clk);
    measure(3, "R6");
    // R7: commit mid-period, old period completes
    tag = "R7"; apply_cfg(16'd6); measure(6, "R7");
    wait_rise();
    commit = 1'b1; cfg_word = 16'd2;
    count_period(hi, lo);
    chk(hi == 3, "R7", "old period high", hi, 3);
    chk(lo == 4, "R7", "old period low", lo, 4);
    count_period(hi, lo);
    chk(hi == 1 && lo == 2, "R7", "new period ticks", hi * 10 + lo, 12);
    // R8: back-to-back commits, last wins
    tag = "R8";
    @(negedge clk); commit = 1'b1; cfg_word = 16'd5;
    @(negedge clk); cfg_word = 16'd10;
    @(negedge clk); commit = 1'b0;
    measure(10, "R8");
    // R8: commit coincident with a boundary (wrap tick at last low cycle)
    apply_cfg(16'd3); measure(3, "R8");
    // now at a rise negedge with h=3 (hi2 lo2); last low cycle is 3 negedges ahead
    repeat (3) @(negedge clk);
    commit = 1'b1; cfg_word = 16'd4;
    @(negedge clk); commit = 1'b0;
    chk(div_rise == 1, "R8", "boundary rise seen", int'(div_rise), 1);
    count_period(hi, lo);
    chk(hi + lo == 4, "R8", "coincident commit deferred", hi + lo, 4);
    count_period(hi, lo);
    chk(hi + lo == 5, "R8", "coincident commit applied", hi + lo, 5);
    // R9: sparse ticks
    tag = "R9"; lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tick = lfsr[0] ^ lfsr[3];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    @(negedge clk); tick = 1'b0;
    hi = int'(div_clk);
    repeat (5) @(negedge clk);
    chk(int'(div_clk) == hi, "R9", "output held without ticks", int'(div_clk), hi);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule